// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block decides, one cycle at a time, whether a write-related request to a small serial memory is accepted or refused. It holds a three-bit status word and a write-enable latch, and it samples an active-low write-protect pin. The status word has a lock bit and a two-bit region code. Requests arrive already decoded from the serial front end. There are four kinds: arm the latch, disarm the latch, load the status word, and write an array byte at a given address. For each request the block answers with a single-cycle accept or reject pulse.

Status loads are refused while the lock bit is set and the synchronized pin is low. This is the hardware lock. It can be entered in either order, either by setting the bit while the pin is low or by lowering the pin while the bit is set. Only raising the pin releases it. Array writes are refused inside an address window that the region code selects from the top of an array of configurable size.

Top module: `write_guard`

## Requirements
- R1: After reset the write-enable latch is 0, the region code is 00, the lock bit is 0, and both response pulses are low.
- R2: `reqKind` encodes 0 = arm latch, 1 = disarm latch, 2 = status load, 3 = array write. An arm request sets `wel` and a disarm request clears it. Both are always accepted.
- R3: While the lock bit is 0, a status load is accepted exactly when `wel` is 1, at either pin level.
- R4: While the lock bit is 1 and the synchronized pin is high, a status load is accepted exactly when `wel` is 1.
- R5: While the lock bit is 1 and the synchronized pin is low, every status load is rejected and the status word stays the same. `hwLocked` reports this state.
- R6: The hardware lock follows the pin through a two-stage synchronizer, so a pin change shows on `hwLocked` after the second rising clock edge. The lock is entered in either order and is left only by raising the pin.
- R7: The protected window is reported as `protActive`/`protLo`. Code 00 protects nothing. Code 01 protects from 3/4·DEPTH upward, code 10 from DEPTH/2 upward, and code 11 the whole array from 0. With DEPTH = 2048 these windows are 0x600, 0x400 and 0x000 up to 0x7FF.
- R8: An array write to an address inside the protected window is rejected. Outside the window it is accepted exactly when `wel` is 1.
- R9: An accepted status load or array write clears `wel` in the same edge in which it takes effect.
- R10: The response to a request comes as a one-cycle pulse on `accept` or `reject`, never both, in the cycle after the request. A rejected request leaves `wel` and the status word unchanged.
- R11: In `reqStatus` bit 2 is the lock bit and bits 1:0 are the region code. The same positions are used to report them on `srwd` and `bpCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wpPinN | input | 1 | Asynchronous active-low write-protect pin |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | Request kind (R2 encoding) |
| reqAddr | input | ADDR_W | Array byte address for array writes |
| reqStatus | input | 3 | New status word for status loads |
| accept | output | 1 | One-cycle accept pulse |
| reject | output | 1 | One-cycle reject pulse |
| wel | output | 1 | Write-enable latch |
| bpCode | output | 2 | Region code |
| srwd | output | 1 | Status lock bit |
| hwLocked | output | 1 | Hardware lock active |
| protActive | output | 1 | Some addresses are protected |
| protLo | output | ADDR_W | Lowest protected address |

## Verification
The assertions assume that `reqKind` and `reqAddr` hold a defined value in every cycle in which `reqValid` is high. They also assume that requests are presented for exactly one cycle each. The stimulus changes every input, the pin included, only on the falling clock edge. It draws request kinds, addresses and status words from a seeded generator over their full ranges, and it toggles the pin at random so that both lock-entry orders occur, on top of directed sequences.

// File: rtl/write_guard_pkg.sv
package write_guard_pkg;

  typedef enum logic [1:0] {
    REQ_SET_LATCH = 2'd0,
    REQ_CLR_LATCH = 2'd1,
    REQ_STATUS_WR = 2'd2,
    REQ_ARRAY_WR  = 2'd3
  } reqKind_e;

  localparam int STAT_W = 3;
  localparam int LOCK_BIT = 2;

  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic loadStatus;
    logic ack;
    logic nak;
  } guardStrobe_t;

endpackage

// File: rtl/write_guard_ctrl.sv
module write_guard_ctrl
  import write_guard_pkg::*;
(
  input  logic         reqValid,
  input  logic [1:0]   reqKind,
  input  logic         wel,
  input  logic         hwLocked,
  input  logic         addrHit,
  output guardStrobe_t strobe
);

  reqKind_e kind;
  assign kind = reqKind_e'(reqKind);

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      unique case (kind)
        REQ_SET_LATCH: begin
          strobe.setLatch = 1'b1;
          strobe.ack      = 1'b1;
        end
        REQ_CLR_LATCH: begin
          strobe.clrLatch = 1'b1;
          strobe.ack      = 1'b1;
        end
        REQ_STATUS_WR: begin
          if (wel && !hwLocked) begin
            strobe.loadStatus = 1'b1;
            strobe.clrLatch   = 1'b1;
            strobe.ack        = 1'b1;
          end else begin
            strobe.nak = 1'b1;
          end
        end
        REQ_ARRAY_WR: begin
          if (wel && !addrHit) begin
            strobe.clrLatch = 1'b1;
            strobe.ack      = 1'b1;
          end else begin
            strobe.nak = 1'b1;
          end
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/write_guard_dp.sv
module write_guard_dp
  import write_guard_pkg::*;
#(
  parameter int DEPTH       = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wpPinN,
  input  guardStrobe_t      strobe,
  input  logic [STAT_W-1:0] newStatus,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              wel,
  output logic [1:0]        bpCode,
  output logic              srwd,
  output logic              hwLocked,
  output logic              protActive,
  output logic [ADDR_W-1:0] protLo,
  output logic              addrHit,
  output logic              accept,
  output logic              reject
);

  localparam logic [ADDR_W-1:0] LO_QUARTER = ADDR_W'(DEPTH - DEPTH / 4);
  localparam logic [ADDR_W-1:0] LO_HALF    = ADDR_W'(DEPTH / 2);
  localparam logic [ADDR_W-1:0] LO_WHOLE   = '0;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;

  // pin synchronizer, reset to the released (high) level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ <= '1;
        else        syncQ <= wpPinN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ <= '1;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], wpPinN};
      end
    end
  endgenerate

  assign pinSync  = syncQ[SYNC_STAGES-1];
  assign hwLocked = srwd & ~pinSync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (strobe.setLatch) begin
      wel <= 1'b1;
    end else if (strobe.clrLatch) begin
      wel <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srwd   <= 1'b0;
      bpCode <= 2'b00;
    end else if (strobe.loadStatus) begin
      srwd   <= newStatus[LOCK_BIT];
      bpCode <= newStatus[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept <= 1'b0;
      reject <= 1'b0;
    end else begin
      accept <= strobe.ack;
      reject <= strobe.nak;
    end
  end

  always_comb begin
    protActive = 1'b1;
    unique case (bpCode)
      2'b01:   protLo = LO_QUARTER;
      2'b10:   protLo = LO_HALF;
      2'b11:   protLo = LO_WHOLE;
      default: begin
        protLo     = LO_WHOLE;
        protActive = 1'b0;
      end
    endcase
  end

  assign addrHit = protActive && (reqAddr >= protLo);

endmodule

// File: rtl/write_guard.sv
module write_guard
  import write_guard_pkg::*;
#(
  parameter int DEPTH   = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wpPinN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqStatus,
  output logic              accept,
  output logic              reject,
  output logic              wel,
  output logic [1:0]        bpCode,
  output logic              srwd,
  output logic              hwLocked,
  output logic              protActive,
  output logic [ADDR_W-1:0] protLo
);

  guardStrobe_t strobe;
  logic         addrHit;

  write_guard_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .wel      (wel),
    .hwLocked (hwLocked),
    .addrHit  (addrHit),
    .strobe   (strobe)
  );

  write_guard_dp #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wpPinN     (wpPinN),
    .strobe     (strobe),
    .newStatus  (reqStatus),
    .reqAddr    (reqAddr),
    .wel        (wel),
    .bpCode     (bpCode),
    .srwd       (srwd),
    .hwLocked   (hwLocked),
    .protActive (protActive),
    .protLo     (protLo),
    .addrHit    (addrHit),
    .accept     (accept),
    .reject     (reject)
  );

endmodule

// File: rtl/write_guard_checker.sv
module write_guard_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              accept,
  input logic              reject,
  input logic              wel,
  input logic [1:0]        bpCode,
  input logic              srwd,
  input logic              hwLocked,
  input logic              protActive,
  input logic [ADDR_W-1:0] protLo
);

  p_set_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == 2'd0 |=> wel && accept);

  p_clr_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == 2'd1 |=> !wel && accept);

  p_open_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == 2'd2 && !srwd && wel |=> accept);

  p_locked_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == 2'd2 && hwLocked |=> reject && !accept);

  p_protected_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == 2'd3 && protActive && reqAddr >= protLo |=> reject);

  p_accept_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && $past(reqValid) && $past(reqKind[1]) |-> !wel);

  p_reject_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $stable(wel) && $stable(bpCode) && $stable(srwd));

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject));

  p_lock_needs_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hwLocked |-> srwd);

endmodule

bind write_guard write_guard_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reqValid   (reqValid),
  .reqKind    (reqKind),
  .reqAddr    (reqAddr),
  .accept     (accept),
  .reject     (reject),
  .wel        (wel),
  .bpCode     (bpCode),
  .srwd       (srwd),
  .hwLocked   (hwLocked),
  .protActive (protActive),
  .protLo     (protLo)
);

// File: tb/write_guard_test.sv
module write_guard_test;

  localparam int DEPTH  = 2048;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wpPinN = 1'b1;
  logic              reqValid = 1'b0;
  logic [1:0]        reqKind = 2'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [2:0]        reqStatus = 3'd0;
  logic              accept, reject, wel, srwd, hwLocked, protActive;
  logic [1:0]        bpCode;
  logic [ADDR_W-1:0] protLo;

  int checks = 0;
  int failures = 0;

  // bench model
  logic mWel = 1'b0, mSrwd = 1'b0;
  logic [1:0] mBp = 2'b00;
  logic mS1 = 1'b1, mS2 = 1'b1;

  always #10 clk = ~clk;

  write_guard #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wpPinN(wpPinN), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqStatus(reqStatus),
    .accept(accept), .reject(reject), .wel(wel), .bpCode(bpCode),
    .srwd(srwd), .hwLocked(hwLocked), .protActive(protActive), .protLo(protLo)
  );

  // pin synchronizer as required by R6
  always @(posedge clk) begin
    if (!rst_n) begin
      mS1 <= 1'b1;
      mS2 <= 1'b1;
    end else begin
      mS1 <= wpPinN;
      mS2 <= mS1;
    end
  end

  function automatic int windowLo(input logic [1:0] code);
    case (code)
      2'b01:   return DEPTH - DEPTH / 4;
      2'b10:   return DEPTH / 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit inWindow(input logic [1:0] code, input int addr);
    return (code != 2'b00) && (addr >= windowLo(code));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check(req, "wel", wel, mWel);
    check(req, "bpCode", bpCode, mBp);
    check(req, "srwd", srwd, mSrwd);
    check(req, "hwLocked", hwLocked, mSrwd && !mS2);
    check("R7", "protActive", protActive, mBp != 2'b00);
    if (mBp != 2'b00) check("R7", "protLo", protLo, windowLo(mBp));
  endtask

  // one request: driven at the falling edge, checked just after the rising edge
  task automatic doReq(input logic [1:0] kind, input int addr, input logic [2:0] stat,
                       input string req);
    bit expAcc;
    @(negedge clk);
    reqValid  = 1'b1;
    reqKind   = kind;
    reqAddr   = ADDR_W'(addr);
    reqStatus = stat;
    case (kind)
      2'd0, 2'd1: expAcc = 1'b1;
      2'd2:       expAcc = mWel && !(mSrwd && !mS2);
      default:    expAcc = mWel && !inWindow(mBp, addr);
    endcase
    @(posedge clk);
    #1;
    if (kind == 2'd0) mWel = 1'b1;
    else if (kind == 2'd1) mWel = 1'b0;
    else if (expAcc) begin
      mWel = 1'b0;
      if (kind == 2'd2) begin
        mSrwd = stat[2];
        mBp   = stat[1:0];
      end
    end
    check(req, "accept", accept, expAcc);
    check(req, "reject", reject, !expAcc);
    checkState(req);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      check(req, "accept idle", accept, 0);
      check(req, "reject idle", reject, 0);
      checkState(req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    check("R1", "wel", wel, 0);
    check("R1", "bpCode", bpCode, 0);
    check("R1", "srwd", srwd, 0);
    check("R1", "accept", accept, 0);
    check("R1", "reject", reject, 0);
    idle(1, "R1");

    // R3 / R9 / R11: load code 01 without and then with the latch
    doReq(2'd2, 0, 3'b001, "R3");
    doReq(2'd0, 0, 3'b000, "R2");
    doReq(2'd2, 0, 3'b001, "R11");
    // R7 / R8 window boundary
    doReq(2'd0, 0, 3'b000, "R2");
    doReq(2'd3, 'h600, 3'b000, "R8");
    doReq(2'd3, 'h5FF, 3'b000, "R8");
    doReq(2'd3, 'h5FF, 3'b000, "R9");
    doReq(2'd0, 0, 3'b000, "R2");
    doReq(2'd1, 0, 3'b000, "R2");
    doReq(2'd3, 'h000, 3'b000, "R8");
    // R3 with pin low, lock bit clear
    @(negedge clk); wpPinN = 1'b0;
    idle(3, "R6");
    doReq(2'd0, 0, 3'b000, "R2");
    doReq(2'd2, 0, 3'b110, "R3");
    // lock entered by setting the bit with pin low: R5
    doReq(2'd0, 0, 3'b000, "R2");
    doReq(2'd2, 0, 3'b000, "R5");
    doReq(2'd2, 0, 3'b011, "R10");
    // leave only by raising the pin: R6 two-edge latency
    @(negedge clk); wpPinN = 1'b1;
    idle(1, "R6");
    idle(1, "R6");
    doReq(2'd2, 0, 3'b111, "R4");
    // other order: bit set with pin high, then lower the pin
    doReq(2'd0, 0, 3'b000, "R2");
    doReq(2'd3, 'h3FF, 3'b000, "R8");
    @(negedge clk); wpPinN = 1'b0;
    idle(2, "R6");
    doReq(2'd0, 0, 3'b000, "R2");
    doReq(2'd2, 0, 3'b000, "R5");
    @(negedge clk); wpPinN = 1'b1;
    idle(2, "R6");
    doReq(2'd2, 0, 3'b100, "R4");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [1:0] k;
      int a;
      logic [2:0] s;
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        wpPinN = ~wpPinN;
      end
      k = 2'($urandom % 4);
      if (($urandom % 3) == 0) k = 2'd0;
      a = int'($urandom % DEPTH);
      s = 3'($urandom % 8);
      doReq(k, a, s, "R10");
      if (($urandom % 4) == 0) idle(1, "R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule